// File: doc/BRIEF.md
# Round-Robin Bus Arbiter with Stalled-Master Lockout

This block is the central arbiter of one shared parallel bus segment. Each of N masters drives an active-low request and receives an active-low grant. The arbiter watches the bus cycle-framing and initiator-ready strobes, both active low, to tell whether the bus is idle. It keeps choosing the next owner while a transfer is still running. The new grant is therefore already in place when the bus frees up, and at most one grant is ever active.

A master can be granted while the bus sits idle and still never start a cycle. If that goes on for a set number of idle clocks (16 by default), the arbiter flags the master as stalled. From then on it ignores that master's request until software clears the flag. When no eligible master is requesting, the grant rests on a default master picked by a configuration input.

Top module: `bus_arbiter_lockout`

## Requirements
- R1: On every clock, at most one bit of `gnt_n` is low. Bit i low means master i is granted.
- R2: While `rst_n` is low, all `gnt_n` bits are high and all `stalled` bits are low.
- R3: If any master that is not stalled drives its request low, then on the next clock edge the grant goes to one of those masters. The selection latency is one clock, well under three.
- R4: Service is round-robin. The search starts at the master after the last owner and wraps around. The last owner is the granted master on a clock where `frame_n` is sampled low right after an idle clock. After reset the last owner is master N-1, so master 0 is searched first.
- R5: The grant can move to the next requester while `frame_n` or `irdy_n` is low. Selection overlaps the running transfer.
- R6: A grant can be withdrawn on any clock, before its holder starts a cycle, so that a requester earlier in the rotation can be served.
- R7: The bus counts as idle on a clock only when `frame_n` and `irdy_n` are both high.
- R8: A master is flagged in `stalled` at the clock edge that samples the 16th consecutive idle clock during which it holds an unchanged grant and keeps its request low. Any non-idle clock or any grant change restarts the count.
- R9: The request of a stalled master is ignored. One clock after the flag rises, the grant has left that master.
- R10: A high `clr_stall[i]` clears `stalled[i]` at the next edge. A clear takes precedence over a flag being set on the same edge.
- R11: When no master that is not stalled is requesting, the grant is parked on master `park_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_n | input | N_MASTERS | Active-low requests, one per master |
| frame_n | input | 1 | Bus cycle-framing strobe, active low |
| irdy_n | input | 1 | Bus initiator-ready strobe, active low |
| park_sel | input | clog2(N_MASTERS) | Index of the master that holds the grant when nobody eligible requests |
| clr_stall | input | N_MASTERS | Per-master clear of the stalled flag |
| gnt_n | output | N_MASTERS | Active-low grants, one per master |
| stalled | output | N_MASTERS | Per-master stalled flag |

## Verification
The assertions assume that `park_sel` always names an existing master. They also assume that the bus strobes change only between clock edges, so every sample is clean. The stimulus uses four masters and only legal park indices. It drives every input at the falling clock edge, and it raises `frame_n` low only after a clock on which both strobes were high. That keeps the recorded owner consistent with a real cycle start.

// File: rtl/bus_arbiter_lockout.sv
module bus_arbiter_lockout #(
  parameter int N_MASTERS  = 4,
  parameter int IDLE_LIMIT = 16
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic [N_MASTERS-1:0]                         req_n,
  input  logic                                         frame_n,
  input  logic                                         irdy_n,
  input  logic [(N_MASTERS>1?$clog2(N_MASTERS):1)-1:0] park_sel,
  input  logic [N_MASTERS-1:0]                         clr_stall,
  output logic [N_MASTERS-1:0]                         gnt_n,
  output logic [N_MASTERS-1:0]                         stalled
);
  localparam int IW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1;
  localparam int CW = $clog2(IDLE_LIMIT + 1);

  logic [N_MASTERS-1:0] gnt_q, gnt_d, stall_q, eligible, stall_set;
  logic [IW-1:0]        last_q, gnt_idx;
  logic [CW-1:0]        cnt_q;
  logic                 idle, idle_q, waiting, found;

  // R7: idle only when both strobes are high
  assign idle     = frame_n & irdy_n;
  assign eligible = ~req_n & ~stall_q;
  assign waiting  = idle & (|(gnt_q & eligible)) & (gnt_d == gnt_q);
  assign gnt_n    = ~gnt_q;
  assign stalled  = stall_q;
  assign stall_set = (waiting && cnt_q == CW'(IDLE_LIMIT - 1)) ? gnt_q : '0;

  always_comb begin
    gnt_idx = '0;
    for (int i = 0; i < N_MASTERS; i++)
      if (gnt_q[i]) gnt_idx = IW'(i);
  end

  // R4: rotating search starting after the last owner; R11: park otherwise
  always_comb begin
    gnt_d = '0;
    found = 1'b0;
    for (int off = 1; off <= N_MASTERS; off++) begin
      if (!found && eligible[(int'(last_q) + off) % N_MASTERS]) begin
        gnt_d[(int'(last_q) + off) % N_MASTERS] = 1'b1;
        found = 1'b1;
      end
    end
    if (!found) gnt_d[park_sel] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_q   <= '0;
      stall_q <= '0;
      last_q  <= IW'(N_MASTERS - 1);
      idle_q  <= 1'b1;
      cnt_q   <= '0;
    end else begin
      gnt_q   <= gnt_d;
      idle_q  <= idle;
      stall_q <= (stall_q | stall_set) & ~clr_stall;
      if (idle_q && !frame_n && (|gnt_q)) last_q <= gnt_idx;
      if (!waiting || cnt_q == CW'(IDLE_LIMIT - 1)) cnt_q <= '0;
      else cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_single_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~gnt_n));

  assert_grant_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|eligible) |=> ((~gnt_n) & $past(eligible)) != '0);

  assert_stall_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|eligible) |=> ((~gnt_n) & $past(stall_q)) == '0);

  assert_park_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(|eligible) |=> !gnt_n[$past(park_sel)]);

  assert_stall_on_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((stall_q & ~$past(stall_q)) != '0) |-> $past(idle));

  assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_stall) |=> (stall_q & $past(clr_stall)) == '0);
endmodule

// File: tb/tb_bus_arbiter_lockout.sv
module tb_bus_arbiter_lockout;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic clk = 0, rst_n = 0, frame_n = 1, irdy_n = 1;
  logic [N-1:0] req_n = '1, clr_stall = '0, gnt_n, stalled;
  logic [1:0] park_sel = '0;
  int runs = 0, fails = 0;

  bus_arbiter_lockout #(.N_MASTERS(N), .IDLE_LIMIT(16)) dut (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .park_sel(park_sel), .clr_stall(clr_stall), .gnt_n(gnt_n), .stalled(stalled));

  always #(CLK_PERIOD/2) clk = ~clk;

  // {req (active high), frame_n, irdy_n, park_sel, expected grant (active high)}
  localparam logic [11:0] VEC [14] = '{
    {4'b0000, 1'b1, 1'b1, 2'd2, 4'b0100},  // R11 park
    {4'b0010, 1'b1, 1'b1, 2'd2, 4'b0010},  // R3
    {4'b0110, 1'b1, 1'b1, 2'd2, 4'b0010},  // R4 from master 0
    {4'b0110, 1'b0, 1'b1, 2'd2, 4'b0010},  // start by 1
    {4'b0100, 1'b0, 1'b0, 2'd2, 4'b0100},  // R5 preselect while busy
    {4'b0100, 1'b1, 1'b0, 2'd2, 4'b0100},
    {4'b0101, 1'b1, 1'b1, 2'd2, 4'b0100},  // R4 after owner 1
    {4'b0101, 1'b0, 1'b1, 2'd2, 4'b0100},  // start by 2
    {4'b0001, 1'b0, 1'b0, 2'd2, 4'b0001},
    {4'b1001, 1'b1, 1'b1, 2'd2, 4'b1000},  // R6 withdraw from 0 for 3
    {4'b1001, 1'b0, 1'b1, 2'd2, 4'b1000},  // start by 3
    {4'b0001, 1'b0, 1'b0, 2'd2, 4'b0001},  // R4 wrap
    {4'b0000, 1'b1, 1'b1, 2'd1, 4'b0010},  // R11
    {4'b0000, 1'b1, 1'b1, 2'd3, 4'b1000}   // R11
  };

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; req_n = '1; frame_n = 1; irdy_n = 1; clr_stall = '0; park_sel = '0;
    repeat (2) @(negedge clk);
    check("R2 grants after reset", gnt_n, 4'b1111);
    check("R2 flags after reset", stalled, 4'b0000);
    rst_n = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    do_reset();
    foreach (VEC[i]) begin
      req_n = ~VEC[i][11:8]; frame_n = VEC[i][7]; irdy_n = VEC[i][6]; park_sel = VEC[i][5:4];
      @(negedge clk);
      check($sformatf("R4 R5 R6 R11 table row %0d", i), ~gnt_n, VEC[i][3:0]);
      check($sformatf("R1 one grant row %0d", i), 4'($onehot0(~gnt_n)), 4'd1);
    end

    // R8: stall flag after 16 idle granted clocks
    do_reset();
    park_sel = 2'd0; req_n = 4'b1011;
    for (int n = 1; n <= 17; n++) begin
      @(negedge clk);
      if (n == 1) check("R3 grant to 2", ~gnt_n, 4'b0100);
      if (n == 16) check("R8 not yet stalled", stalled, 4'b0000);
      if (n == 17) check("R8 stalled at 16th idle", stalled, 4'b0100);
    end
    @(negedge clk);
    check("R9 stalled request ignored, parked", ~gnt_n, 4'b0001);
    @(negedge clk);
    check("R9 still ignored", ~gnt_n, 4'b0001);
    clr_stall = 4'b0100;
    @(negedge clk);
    clr_stall = '0;
    check("R10 flag cleared", stalled, 4'b0000);
    @(negedge clk);
    check("R10 served again", ~gnt_n, 4'b0100);

    // R8: a busy clock restarts the count
    do_reset();
    req_n = 4'b1101;
    repeat (11) @(negedge clk);
    frame_n = 0; irdy_n = 0;
    @(negedge clk);
    frame_n = 1; irdy_n = 1;
    repeat (12) @(negedge clk);
    check("R8 count restarted by busy clock", stalled, 4'b0000);
    check("R7 grant held on 1", ~gnt_n, 4'b0010);

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule